// File: doc/BRIEF.md
# Storage Drive Interface Register Block

This block is the register and interrupt front end of a storage-drive interface. Software reaches it through a 32-bit register bus with an 8-bit byte offset. It holds an interrupt status register, a cover register, three command words, a DMA address, a DMA length, a transfer control word, an immediate-data buffer and a read-only configuration word.

Writing the start bit in the control word begins a transfer. A modeled drive then sends one done beat for each 32-byte block it moves, and each beat takes 32 off the length. The beat that brings the length to zero ends the transfer. It raises the transfer-complete flag and drops the start bit.

Each event source has a sticky flag and an enable mask. A flag is cleared by writing 1 to it, and the masks are written directly. The interrupt output is the OR of every flag that is enabled by its mask. A break request bit is handed to the drive, and the drive acknowledges it on a separate pin. There is no data path here, so none of the pins is a stream. All pins are plain control and status, and the register bus completes every write in one cycle with no back-pressure.

Top module: `disc_regblk`

## Requirements
- R1: After reset every register reads zero, `irq` and `xfer_busy` are low, and the configuration word at offset 0x24 reads the parameter `CFG_VALUE` (default 0x00000001).
- R2: Status is at offset 0x00. Its flags are error (bit 0), transfer complete (bit 1) and break complete (bit 2). Its masks are error (bit 4), transfer complete (bit 5) and break complete (bit 6). The break request is bit 8. A status write loads the three masks and the break request from the write data. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R3: Cover is at offset 0x04, with the flag in bit 0 and the mask in bit 1. A `cover_chg` pulse sets the flag. Writing 1 to bit 0 clears the flag, and bit 1 is written directly.
- R4: The DMA address at offset 0x14 stores the write data ANDed with 0x03FFFFE0.
- R5: The DMA length at offset 0x18 stores the write data with bits 4:0 forced to 0.
- R6: Control is at offset 0x1C and keeps only write bits 2:0. Bit 0 is the start bit, and `xfer_busy` equals it.
- R7: While start is 1, each `done_beat` lowers the length by 32. The beat that arrives with the length at 32 or less sets the length to 0, sets the transfer-complete flag and clears the start bit. Control bits 2:1 are kept.
- R8: A `done_beat` while start is 0 sets the error flag and leaves the length unchanged.
- R9: `brk_ack` while the break request is 1 sets the break-complete flag and clears the request. While the request is 0, `brk_ack` has no effect.
- R10: `irq` is 1 exactly when some flag and its matching mask are both 1. It follows the register state in the same cycle.
- R11: A write to offset 0x24 is ignored. The command words at 0x08, 0x0C and 0x10 and the immediate buffer at 0x20 store and read back all 32 bits. Unmapped offsets read 0.
- R12: When a hardware set event and a write-1 clear hit the same flag in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| done_beat | input | 1 | One 32-byte block moved by the drive |
| brk_ack | input | 1 | Drive acknowledges the break request |
| cover_chg | input | 1 | Cover state changed |
| xfer_busy | output | 1 | Start bit, a transfer in progress |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check several rules on every cycle. A set event always leaves its flag high, and a lone write-1 clears it. The stored address and length never hold bits outside their allowed range. Each beat lowers the length by exactly 32 or finishes the transfer. A break acknowledge only counts while a request is pending, and `irq` stays low when no flag is set. The bench scenarios cover the rest: the register offsets and bit positions seen by software, the read-back of every register, the fact that writes to the configuration word are ignored, and a full multi-beat transfer whose interrupt is raised and then cleared through the mask and flag bits.

// File: rtl/disc_regblk_pkg.sv
package disc_regblk_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_W  = 8;

  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h00;
  localparam logic [OFS_W-1:0] OFS_COVER  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CMD0   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CMD1   = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_CMD2   = 8'h10;
  localparam logic [OFS_W-1:0] OFS_DADDR  = 8'h14;
  localparam logic [OFS_W-1:0] OFS_DLEN   = 8'h18;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h1C;
  localparam logic [OFS_W-1:0] OFS_IMM    = 8'h20;
  localparam logic [OFS_W-1:0] OFS_CFG    = 8'h24;

  localparam int unsigned NUM_SRC = 4;
  typedef enum logic [1:0] {
    SRC_ERR = 2'd0,
    SRC_TC  = 2'd1,
    SRC_BRK = 2'd2,
    SRC_COV = 2'd3
  } src_e;

  localparam int unsigned ST_MASK_LSB = 4;
  localparam int unsigned ST_BRKREQ   = 8;
  localparam int unsigned CTL_W       = 3;
endpackage

// File: rtl/disc_flag_pair.sv
module disc_flag_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic w1c_i,
  input  logic mask_we,
  input  logic mask_d,
  output logic flag_o,
  output logic mask_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      mask_o <= 1'b0;
    end else begin
      if (set_i)      flag_o <= 1'b1;
      else if (w1c_i) flag_o <= 1'b0;
      if (mask_we)    mask_o <= mask_d;
    end
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_i && !set_i) |=> !flag_o);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!w1c_i && !set_i && flag_o) |=> flag_o);
endmodule

// File: rtl/disc_xfer_ctrl.sv
module disc_xfer_ctrl #(
  parameter int unsigned DW         = 32,
  parameter int unsigned ALIGN_BITS = 5,
  parameter int unsigned SPAN_BITS  = 26,
  parameter int unsigned CW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_addr,
  input  logic          wr_len,
  input  logic          wr_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          done_beat,
  output logic [DW-1:0] dma_addr,
  output logic [DW-1:0] dma_len,
  output logic [CW-1:0] ctl,
  output logic          tc_set,
  output logic          err_set
);
  localparam logic [DW-1:0] LOW_MASK  = DW'((64'd1 << ALIGN_BITS) - 64'd1);
  localparam logic [DW-1:0] SPAN_MASK = DW'((64'd1 << SPAN_BITS) - 64'd1);
  localparam logic [DW-1:0] ADDR_KEEP = SPAN_MASK & ~LOW_MASK;
  localparam logic [DW-1:0] STEP      = DW'(64'd1 << ALIGN_BITS);

  logic start, beat_ok, finish;
  assign start   = ctl[0];
  assign beat_ok = done_beat && start;
  assign finish  = beat_ok && (dma_len <= STEP);
  assign tc_set  = finish;
  assign err_set = done_beat && !start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_addr <= '0;
      dma_len  <= '0;
      ctl      <= '0;
    end else begin
      if (wr_addr) dma_addr <= wdata & ADDR_KEEP;
      if (wr_len)       dma_len <= wdata & ~LOW_MASK;
      else if (finish)  dma_len <= '0;
      else if (beat_ok) dma_len <= dma_len - STEP;
      if (wr_ctl)      ctl <= wdata[CW-1:0];
      else if (finish) ctl[0] <= 1'b0;
    end
  end

  assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_addr & ~ADDR_KEEP) == '0);
  assert_len_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_len & LOW_MASK) == '0);
  assert_len_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !wr_len && dma_len > STEP) |=> dma_len == $past(dma_len) - STEP);
  assert_finish_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !wr_ctl && !wr_len) |=> (!ctl[0] && dma_len == '0));
  assert_idle_len_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_beat && !start && !wr_len) |=> $stable(dma_len));
endmodule

// File: rtl/disc_regblk.sv
module disc_regblk
  import disc_regblk_pkg::*;
#(
  parameter logic [31:0] CFG_VALUE = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        done_beat,
  input  logic        brk_ack,
  input  logic        cover_chg,
  output logic        xfer_busy,
  output logic        irq
);
  logic wr_st, wr_cov, wr_addr_r, wr_len_r, wr_ctl_r, wr_imm;
  logic [2:0] wr_cmd;
  assign wr_st     = reg_wr_en && reg_addr == OFS_STATUS;
  assign wr_cov    = reg_wr_en && reg_addr == OFS_COVER;
  assign wr_cmd[0] = reg_wr_en && reg_addr == OFS_CMD0;
  assign wr_cmd[1] = reg_wr_en && reg_addr == OFS_CMD1;
  assign wr_cmd[2] = reg_wr_en && reg_addr == OFS_CMD2;
  assign wr_addr_r = reg_wr_en && reg_addr == OFS_DADDR;
  assign wr_len_r  = reg_wr_en && reg_addr == OFS_DLEN;
  assign wr_ctl_r  = reg_wr_en && reg_addr == OFS_CTRL;
  assign wr_imm    = reg_wr_en && reg_addr == OFS_IMM;

  logic [DATA_W-1:0] dma_addr, dma_len;
  logic [CTL_W-1:0]  ctl;
  logic              tc_set, err_set;

  disc_xfer_ctrl #(.DW(DATA_W), .ALIGN_BITS(5), .SPAN_BITS(26), .CW(CTL_W)) xfer_i (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr_r), .wr_len(wr_len_r),
    .wr_ctl(wr_ctl_r), .wdata(reg_wdata), .done_beat(done_beat),
    .dma_addr(dma_addr), .dma_len(dma_len), .ctl(ctl),
    .tc_set(tc_set), .err_set(err_set)
  );
  assign xfer_busy = ctl[0];

  logic brk_req, brk_set;
  assign brk_set = brk_ack && brk_req;
  always_ff @(posedge clk) begin
    if (!rst_n)       brk_req <= 1'b0;
    else if (wr_st)   brk_req <= reg_wdata[ST_BRKREQ];
    else if (brk_set) brk_req <= 1'b0;
  end

  logic [NUM_SRC-1:0] set_v, w1c_v, mwe_v, md_v, flag_v, mask_v;
  assign set_v = {cover_chg, brk_set, tc_set, err_set};
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      if (g == int'(SRC_COV)) begin : g_cov
        assign w1c_v[g] = wr_cov && reg_wdata[0];
        assign mwe_v[g] = wr_cov;
        assign md_v[g]  = reg_wdata[1];
      end else begin : g_st
        assign w1c_v[g] = wr_st && reg_wdata[g];
        assign mwe_v[g] = wr_st;
        assign md_v[g]  = reg_wdata[ST_MASK_LSB+g];
      end
      disc_flag_pair pair_i (
        .clk(clk), .rst_n(rst_n), .set_i(set_v[g]), .w1c_i(w1c_v[g]),
        .mask_we(mwe_v[g]), .mask_d(md_v[g]),
        .flag_o(flag_v[g]), .mask_o(mask_v[g])
      );
    end
  endgenerate

  assign irq = |(flag_v & mask_v);

  logic [DATA_W-1:0] cmd_q [3];
  logic [DATA_W-1:0] imm_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) cmd_q[i] <= '0;
      imm_q <= '0;
    end else begin
      for (int i = 0; i < 3; i++) if (wr_cmd[i]) cmd_q[i] <= reg_wdata;
      if (wr_imm) imm_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STATUS: begin
        reg_rdata[2:0] = flag_v[2:0];
        reg_rdata[ST_MASK_LSB +: 3] = mask_v[2:0];
        reg_rdata[ST_BRKREQ] = brk_req;
      end
      OFS_COVER: reg_rdata[1:0] = {mask_v[SRC_COV], flag_v[SRC_COV]};
      OFS_CMD0:  reg_rdata = cmd_q[0];
      OFS_CMD1:  reg_rdata = cmd_q[1];
      OFS_CMD2:  reg_rdata = cmd_q[2];
      OFS_DADDR: reg_rdata = dma_addr;
      OFS_DLEN:  reg_rdata = dma_len;
      OFS_CTRL:  reg_rdata[CTL_W-1:0] = ctl;
      OFS_IMM:   reg_rdata = imm_q;
      OFS_CFG:   reg_rdata = CFG_VALUE;
      default:   reg_rdata = '0;
    endcase
  end

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_v == '0) |-> !irq);
  assert_brk_ack_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack && !brk_req && !wr_st && !flag_v[SRC_BRK]) |=> !flag_v[SRC_BRK]);
  assert_brk_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack && brk_req && !wr_st) |=> (!brk_req && flag_v[SRC_BRK]));
endmodule

// File: tb/disc_regblk_tb_top.sv
module disc_regblk_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, reg_wr_en, done_beat, brk_ack, cover_chg;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        xfer_busy, irq;
  int errors = 0, checks = 0;

  disc_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_beat(done_beat),
    .brk_ack(brk_ack), .cover_chg(cover_chg), .xfer_busy(xfer_busy), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", 8'h00, 32'h0);
    rd_chk("R1 length", 8'h18, 32'h0);
    rd_chk("R1 config", 8'h24, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 busy", {31'b0, xfer_busy}, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h14, 32'hFFFF_FFFF);
    rd_chk("R4 addr mask", 8'h14, 32'h03FF_FFE0);
    wr(8'h18, 32'h0000_123F);
    rd_chk("R5 length align", 8'h18, 32'h0000_1220);
    wr(8'h08, 32'hA5A5_0001); wr(8'h0C, 32'h5A5A_0002); wr(8'h10, 32'hDEAD_BEEF);
    wr(8'h20, 32'h1234_5678);
    rd_chk("R11 cmd0", 8'h08, 32'hA5A5_0001);
    rd_chk("R11 cmd2", 8'h10, 32'hDEAD_BEEF);
    rd_chk("R11 imm", 8'h20, 32'h1234_5678);
    wr(8'h24, 32'hFFFF_0000);
    rd_chk("R11 config ignores write", 8'h24, 32'h1);
    rd_chk("R11 unmapped", 8'h40, 32'h0);
    wr(8'h1C, 32'hFFFF_FFF6);
    rd_chk("R6 control low bits", 8'h1C, 32'h6);
    chk("R6 busy low", {31'b0, xfer_busy}, 32'h0);
  endtask

  task automatic t_transfer;
    wr(8'h00, 32'h0000_0020);
    wr(8'h18, 32'h0000_005F);
    wr(8'h1C, 32'h0000_0007);
    chk("R6 busy after start", {31'b0, xfer_busy}, 32'h1);
    pulse(done_beat);
    rd_chk("R7 length after beat", 8'h18, 32'h20);
    chk("R7 still busy", {31'b0, xfer_busy}, 32'h1);
    chk("R10 irq low mid transfer", {31'b0, irq}, 32'h0);
    pulse(done_beat);
    rd_chk("R7 length done", 8'h18, 32'h0);
    rd_chk("R7 control after finish", 8'h1C, 32'h6);
    rd_chk("R7 tc flag", 8'h00, 32'h0000_0022);
    chk("R10 irq on tc", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0000_0000);
    chk("R10 irq masked off", {31'b0, irq}, 32'h0);
    rd_chk("R2 zero leaves flag", 8'h00, 32'h0000_0002);
    wr(8'h00, 32'h0000_0002);
    rd_chk("R2 w1c clears tc", 8'h00, 32'h0);
  endtask

  task automatic t_error;
    wr(8'h18, 32'h0000_0040);
    pulse(done_beat);
    rd_chk("R8 error flag", 8'h00, 32'h0000_0001);
    rd_chk("R8 length unchanged", 8'h18, 32'h40);
    wr(8'h00, 32'h0000_0011);
    rd_chk("R2 mask loaded, flag cleared", 8'h00, 32'h0000_0010);
  endtask

  task automatic t_break;
    wr(8'h00, 32'h0000_0140);
    rd_chk("R2 break request", 8'h00, 32'h0000_0140);
    pulse(brk_ack);
    rd_chk("R9 break done", 8'h00, 32'h0000_0044);
    chk("R10 irq on break", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0000_0044);
    pulse(brk_ack);
    rd_chk("R9 ack ignored without request", 8'h00, 32'h0000_0040);
    chk("R9 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_cover;
    wr(8'h00, 32'h0);
    pulse(cover_chg);
    rd_chk("R3 cover flag", 8'h04, 32'h1);
    chk("R3 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h2);
    rd_chk("R3 mask set", 8'h04, 32'h3);
    chk("R10 irq on cover", {31'b0, irq}, 32'h1);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'h04; reg_wdata = 32'h3; cover_chg = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; cover_chg = 1'b0;
    rd_chk("R12 set beats clear", 8'h04, 32'h3);
    wr(8'h04, 32'h1);
    rd_chk("R3 w1c cover", 8'h04, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    done_beat = 1'b0; brk_ack = 1'b0; cover_chg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_transfer();
    t_error();
    t_break();
    t_cover();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule